// File: doc/BRIEF.md
# Command Word Method Expander

This block sits after a command fetch unit and turns a stream of 32-bit command words into single method writes. A header word carries a 3-bit opcode in bits 31:29, a 13-bit count or immediate value in bits 28:16, a subchannel in bits 15:13 and a 12-bit method address in bits 11:0. A burst header sets up a run of data words. Each data word that follows becomes one write whose address advances according to the burst mode. An immediate header produces its single write directly from the header word.

Each write goes to exactly one target, chosen by its method address. Low addresses go to a small local register file, addressed in bytes. Mid-range addresses go to an engine port tagged with the subchannel. High addresses go to a macro port, which carries a start strobe or an argument strobe, a macro index and a last-call flag. Words arrive on a valid/ready interface. If the selected target is not ready, the incoming word waits.

Top module: `cmd_method_expander`

## Requirements
- R1: Opcode 1 starts an incrementing burst: the next count words each produce one write, to the header address, then address+1, and so on, using the header's subchannel.
- R2: Opcode 3 starts a non-incrementing burst: every one of its count data words writes the header address.
- R3: Opcode 5 starts an increment-once burst: the first data word writes the header address and every later data word writes header address+1.
- R4: Opcode 4 produces one write to the header address at once, with data equal to header bits 28:16 zero-extended, and consumes no data words.
- R5: While the remaining count is nonzero, every accepted word is data and the count drops by one. A header is decoded only at count zero, so a burst header with count 0 produces no write.
- R6: Method addresses below 0x60 strobe the register port with byte address method*4.
- R7: Method addresses from 0x60 to 0xDFF strobe the engine port with the method address and the current subchannel.
- R8: Method addresses from 0xE00 upward strobe the macro port with index (method>>1)&0x7F. An odd address raises the argument strobe and an even address raises the start strobe.
- R9: The macro last-call flag is high on the final data write of a burst (remaining count 1) and on every immediate write, and low otherwise.
- R10: Opcodes 0, 2, 6 and 7 are taken as single words that cause no write and leave the burst state unchanged.
- R11: While a pending write's target (engine or macro) holds its ready low, the write strobe stays up and the input ready stays low. The register port always accepts.
- R12: After reset the count is zero and no strobe is active, so the first word accepted is decoded as a header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_valid | input | 1 | Command word present |
| word_data | input | 32 | Command word |
| word_ready | output | 1 | Word taken on this edge when valid |
| reg_we | output | 1 | Local register write strobe |
| reg_addr | output | 9 | Register byte address (method*4) |
| reg_wdata | output | 32 | Register write data |
| eng_we | output | 1 | Engine write request |
| eng_ready | input | 1 | Engine accepts the request |
| eng_subch | output | 3 | Subchannel of the engine write |
| eng_method | output | 12 | Engine method address |
| eng_wdata | output | 32 | Engine write data |
| mac_start | output | 1 | Macro start request (even method) |
| mac_push | output | 1 | Macro argument request (odd method) |
| mac_ready | input | 1 | Macro port accepts the request |
| mac_index | output | 7 | Macro index |
| mac_wdata | output | 32 | Macro argument data |
| mac_last | output | 1 | Last write of the call |

## Verification
The bench builds the block with its default parameters: a 13-bit count, a 12-bit method address, a register range ending at 0x60 and an engine range ending at 0xE00. With these limits the bench can place writes on both sides of each range edge (0x5F/0x60 and 0xDFF/0xE00). It can also check macro indices derived from odd and even addresses, and the immediate field widened to 32 bits. Short bursts of three words are enough to show how each increment mode advances the address and where the last-call flag falls.

// File: rtl/cmd_exp_pkg.sv
// Shared encodings for the command word method expander.
// Assumes a 32-bit command word with the opcode in the top three bits.
package cmd_exp_pkg;
    typedef enum logic [2:0] {
        OP_GRP0   = 3'd0,
        OP_INC    = 3'd1,
        OP_GRP2   = 3'd2,
        OP_NONINC = 3'd3,
        OP_IMM    = 3'd4,
        OP_ONCE   = 3'd5,
        OP_RSV6   = 3'd6,
        OP_RSV7   = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        TGT_REG = 2'd0,
        TGT_ENG = 2'd1,
        TGT_MAC = 2'd2
    } tgt_e;

    // Field positions inside a header word
    localparam int OP_LSB    = 29;
    localparam int CNT_LSB   = 16;
    localparam int SUB_LSB   = 13;
    localparam int ADDR_LSB  = 0;
endpackage

// File: rtl/cmd_hdr_fields.sv
// Splits a command word into header fields and classifies the opcode.
// Purely combinational; assumes the word is only meaningful as a header
// when the burst tracker reports count zero.
module cmd_hdr_fields
    import cmd_exp_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int METHOD_W = 12,
    parameter int SUBCH_W  = 3,
    parameter int COUNT_W  = 13
) (
    input  logic [WORD_W-1:0]   word,
    output op_e                 op,
    output logic [METHOD_W-1:0] addr,
    output logic [SUBCH_W-1:0]  subch,
    output logic [COUNT_W-1:0]  count,
    output logic                is_burst,
    output logic                is_imm
);
    // Field extraction and opcode class
    always_comb begin
        op       = op_e'(word[OP_LSB +: 3]);
        addr     = word[ADDR_LSB +: METHOD_W];
        subch    = word[SUB_LSB +: SUBCH_W];
        count    = word[CNT_LSB +: COUNT_W];
        is_burst = (op == OP_INC) || (op == OP_NONINC) || (op == OP_ONCE);
        is_imm   = (op == OP_IMM);
    end
endmodule

// File: rtl/cmd_burst_track.sv
// Holds burst state (method, subchannel, remaining count, increment mode)
// and forms the pending write for the word on the input.
// Assumes 'accept' is high only on a completed input handshake.
module cmd_burst_track
    import cmd_exp_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int METHOD_W = 12,
    parameter int SUBCH_W  = 3,
    parameter int COUNT_W  = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                word_valid,
    input  logic [WORD_W-1:0]   word,
    input  logic                accept,
    input  op_e                 h_op,
    input  logic [METHOD_W-1:0] h_addr,
    input  logic [SUBCH_W-1:0]  h_subch,
    input  logic [COUNT_W-1:0]  h_count,
    input  logic                h_burst,
    input  logic                h_imm,
    output logic                wr_req,
    output logic [METHOD_W-1:0] wr_method,
    output logic [SUBCH_W-1:0]  wr_subch,
    output logic [WORD_W-1:0]   wr_data,
    output logic                wr_last
);
    logic [COUNT_W-1:0]  remain;
    logic [METHOD_W-1:0] cur_meth;
    logic [SUBCH_W-1:0]  cur_sub;
    logic                hold_addr;
    logic                once_mode;
    logic                busy;

    assign busy = (remain != '0);

    // Pending write: data word in a burst, or an immediate header
    always_comb begin
        wr_req    = word_valid && (busy || h_imm);
        wr_method = busy ? cur_meth : h_addr;
        wr_subch  = busy ? cur_sub  : h_subch;
        wr_data   = busy ? word : WORD_W'(h_count);
        wr_last   = busy ? (remain == COUNT_W'(1)) : 1'b1;
    end

    // Burst state update on each accepted word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain    <= '0;
            cur_meth  <= '0;
            cur_sub   <= '0;
            hold_addr <= 1'b0;
            once_mode <= 1'b0;
        end else if (accept) begin
            if (busy) begin
                remain <= remain - COUNT_W'(1);
                if (!hold_addr) cur_meth <= cur_meth + METHOD_W'(1);
                if (once_mode)  hold_addr <= 1'b1;
            end else if (h_burst) begin
                remain    <= h_count;
                cur_meth  <= h_addr;
                cur_sub   <= h_subch;
                hold_addr <= (h_op == OP_NONINC);
                once_mode <= (h_op == OP_ONCE);
            end
        end
    end

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && accept) |=> (remain == $past(remain) - COUNT_W'(1)));

    // R2
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && accept && hold_addr) |=> (cur_meth == $past(cur_meth)));

    // R10
    ignored_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && accept && !h_burst) |=> (remain == '0) && $stable(cur_meth) && $stable(cur_sub));

    // R12
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (remain == '0));
endmodule

// File: rtl/cmd_write_route.sv
// Steers a pending write to the register, engine or macro port by method
// address range and reports whether the chosen target takes it this cycle.
// Assumes REG_LIMIT < ENG_LIMIT.
module cmd_write_route
    import cmd_exp_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int METHOD_W   = 12,
    parameter int SUBCH_W    = 3,
    parameter int REG_LIMIT  = 'h60,
    parameter int ENG_LIMIT  = 'hE00,
    parameter int MIDX_W     = 7,
    parameter int REG_ADDR_W = $clog2(REG_LIMIT * 4)
) (
    input  logic                  wr_req,
    input  logic [METHOD_W-1:0]   wr_method,
    input  logic [SUBCH_W-1:0]    wr_subch,
    input  logic [WORD_W-1:0]     wr_data,
    input  logic                  wr_last,
    input  logic                  eng_ready,
    input  logic                  mac_ready,
    output logic                  wr_ok,
    output logic                  reg_we,
    output logic [REG_ADDR_W-1:0] reg_addr,
    output logic [WORD_W-1:0]     reg_wdata,
    output logic                  eng_we,
    output logic [SUBCH_W-1:0]    eng_subch,
    output logic [METHOD_W-1:0]   eng_method,
    output logic [WORD_W-1:0]     eng_wdata,
    output logic                  mac_start,
    output logic                  mac_push,
    output logic [MIDX_W-1:0]     mac_index,
    output logic [WORD_W-1:0]     mac_wdata,
    output logic                  mac_last
);
    tgt_e tgt;

    // Range decode of the method address
    always_comb begin
        if (32'(wr_method) < REG_LIMIT)      tgt = TGT_REG;
        else if (32'(wr_method) < ENG_LIMIT) tgt = TGT_ENG;
        else                                 tgt = TGT_MAC;
    end

    // Per-target strobes and payloads
    always_comb begin
        reg_we     = wr_req && (tgt == TGT_REG);
        reg_addr   = REG_ADDR_W'({wr_method, 2'b00});
        reg_wdata  = wr_data;
        eng_we     = wr_req && (tgt == TGT_ENG);
        eng_subch  = wr_subch;
        eng_method = wr_method;
        eng_wdata  = wr_data;
        mac_start  = wr_req && (tgt == TGT_MAC) && !wr_method[0];
        mac_push   = wr_req && (tgt == TGT_MAC) &&  wr_method[0];
        mac_index  = wr_method[MIDX_W:1];
        mac_wdata  = wr_data;
        mac_last   = wr_last;
        case (tgt)
            TGT_ENG: wr_ok = eng_ready;
            TGT_MAC: wr_ok = mac_ready;
            default: wr_ok = 1'b1;
        endcase
    end

    // R6 R7 R8: a write lands on exactly one port
    always_comb begin
        one_target_chk: assert ($onehot0({reg_we, eng_we, mac_start, mac_push}));
    end
endmodule

// File: rtl/cmd_method_expander.sv
// Top: expands compressed command headers into single method writes and
// routes them by address range. Input ready is withheld while the target
// of the pending write is busy. Assumes registered consumers on all ports.
module cmd_method_expander
    import cmd_exp_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int METHOD_W   = 12,
    parameter int SUBCH_W    = 3,
    parameter int COUNT_W    = 13,
    parameter int REG_LIMIT  = 'h60,
    parameter int ENG_LIMIT  = 'hE00,
    parameter int MIDX_W     = 7,
    parameter int REG_ADDR_W = $clog2(REG_LIMIT * 4)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  word_valid,
    input  logic [WORD_W-1:0]     word_data,
    output logic                  word_ready,
    output logic                  reg_we,
    output logic [REG_ADDR_W-1:0] reg_addr,
    output logic [WORD_W-1:0]     reg_wdata,
    output logic                  eng_we,
    input  logic                  eng_ready,
    output logic [SUBCH_W-1:0]    eng_subch,
    output logic [METHOD_W-1:0]   eng_method,
    output logic [WORD_W-1:0]     eng_wdata,
    output logic                  mac_start,
    output logic                  mac_push,
    input  logic                  mac_ready,
    output logic [MIDX_W-1:0]     mac_index,
    output logic [WORD_W-1:0]     mac_wdata,
    output logic                  mac_last
);
    op_e                 h_op;
    logic [METHOD_W-1:0] h_addr;
    logic [SUBCH_W-1:0]  h_subch;
    logic [COUNT_W-1:0]  h_count;
    logic                h_burst, h_imm;
    logic                wr_req, wr_last, wr_ok, accept;
    logic [METHOD_W-1:0] wr_method;
    logic [SUBCH_W-1:0]  wr_subch;
    logic [WORD_W-1:0]   wr_data;

    cmd_hdr_fields #(.WORD_W(WORD_W), .METHOD_W(METHOD_W), .SUBCH_W(SUBCH_W),
                     .COUNT_W(COUNT_W)) u_fields (
        .word(word_data), .op(h_op), .addr(h_addr), .subch(h_subch),
        .count(h_count), .is_burst(h_burst), .is_imm(h_imm));

    cmd_burst_track #(.WORD_W(WORD_W), .METHOD_W(METHOD_W), .SUBCH_W(SUBCH_W),
                      .COUNT_W(COUNT_W)) u_track (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word(word_data),
        .accept(accept), .h_op(h_op), .h_addr(h_addr), .h_subch(h_subch),
        .h_count(h_count), .h_burst(h_burst), .h_imm(h_imm),
        .wr_req(wr_req), .wr_method(wr_method), .wr_subch(wr_subch),
        .wr_data(wr_data), .wr_last(wr_last));

    cmd_write_route #(.WORD_W(WORD_W), .METHOD_W(METHOD_W), .SUBCH_W(SUBCH_W),
                      .REG_LIMIT(REG_LIMIT), .ENG_LIMIT(ENG_LIMIT),
                      .MIDX_W(MIDX_W), .REG_ADDR_W(REG_ADDR_W)) u_route (
        .wr_req(wr_req), .wr_method(wr_method), .wr_subch(wr_subch),
        .wr_data(wr_data), .wr_last(wr_last), .eng_ready(eng_ready),
        .mac_ready(mac_ready), .wr_ok(wr_ok),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .eng_we(eng_we), .eng_subch(eng_subch), .eng_method(eng_method),
        .eng_wdata(eng_wdata), .mac_start(mac_start), .mac_push(mac_push),
        .mac_index(mac_index), .mac_wdata(mac_wdata), .mac_last(mac_last));

    // Input handshake: hold the word while its write target is busy
    always_comb begin
        word_ready = !wr_req || wr_ok;
        accept     = word_valid && word_ready;
    end

    // R11
    eng_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_we && !eng_ready) |-> !word_ready);

    // R11
    mac_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mac_start || mac_push) && !mac_ready) |-> !word_ready);
endmodule

// File: tb/cmd_method_expander_test.sv
`timescale 1ns/1ps
module cmd_method_expander_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic word_ready;
    logic reg_we; logic [8:0] reg_addr; logic [31:0] reg_wdata;
    logic eng_we; logic eng_ready = 1'b1; logic [2:0] eng_subch;
    logic [11:0] eng_method; logic [31:0] eng_wdata;
    logic mac_start, mac_push; logic mac_ready = 1'b1;
    logic [6:0] mac_index; logic [31:0] mac_wdata; logic mac_last;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Expected write: {target[1:0], addr[13:0], sub[2:0], last, data[31:0]}
    typedef struct { logic [51:0] v; string tag; } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;

    cmd_method_expander uut (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
        .word_ready(word_ready), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .eng_we(eng_we), .eng_ready(eng_ready),
        .eng_subch(eng_subch), .eng_method(eng_method), .eng_wdata(eng_wdata),
        .mac_start(mac_start), .mac_push(mac_push), .mac_ready(mac_ready),
        .mac_index(mac_index), .mac_wdata(mac_wdata), .mac_last(mac_last));

    function automatic logic [31:0] hdr(input int op, input int sub, input int cnt, input int addr);
        return {3'(op), 13'(cnt), 3'(sub), 1'b0, 12'(addr)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [51:0] act, input logic [51:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected write from method address, following the range rules
    task automatic expect_wr(input int meth, input int sub, input logic [31:0] d,
                             input bit last, input string tag);
        exp_t e;
        if (meth < 'h60)       e.v = {2'd0, 14'(meth * 4), 3'd0, 1'b0, d};
        else if (meth < 'hE00) e.v = {2'd1, 14'(meth), 3'(sub), 1'b0, d};
        else                   e.v = {2'd2, 6'd0, 7'((meth >> 1) & 'h7F), 1'(meth & 1), 3'd0, last, d};
        e.tag = tag;
        q.push_back(e);
    endtask

    // Driver: present one word and hold it until taken
    task automatic send(input logic [31:0] w);
        word_valid = 1'b1;
        word_data  = w;
        forever begin
            @(negedge clk);
            if (word_ready) break;
        end
        @(posedge clk);
        #1 word_valid = 1'b0;
    endtask

    // Monitor: compare every accepted write with the scoreboard head
    always @(negedge clk) begin
        logic [51:0] act;
        bit fire;
        fire = 1'b0;
        act = '0;
        if (rst_n && reg_we) begin
            fire = 1'b1; act = {2'd0, 5'd0, reg_addr, 3'd0, 1'b0, reg_wdata};
        end else if (rst_n && eng_we && eng_ready) begin
            fire = 1'b1; act = {2'd1, 2'd0, eng_method, eng_subch, 1'b0, eng_wdata};
        end else if (rst_n && (mac_start || mac_push) && mac_ready) begin
            fire = 1'b1; act = {2'd2, 6'd0, mac_index, mac_push, 3'd0, mac_last, mac_wdata};
        end
        if (fire) begin
            if (q.size() == 0) chk(1'b0, "R10 unexpected write", act, '0);
            else begin
                exp_t e;
                e = q.pop_front();
                chk(act == e.v, e.tag, act, e.v);
            end
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R12: no strobe, ready high while held in reset
        @(negedge clk);
        chk({reg_we, eng_we, mac_start, mac_push} == 4'b0 && word_ready, "R12 reset outputs",
            52'({reg_we, eng_we, mac_start, mac_push, word_ready}), 52'b1);
        @(posedge clk); #1 rst_n = 1'b1;

        // R12 R4 R6: first word after reset is a header; immediate to register 0x05
        expect_wr('h05, 0, 32'h1ABC, 1, "R4 imm reg");
        send(hdr(4, 0, 'h1ABC, 'h05));
        // R4 R7: immediate to engine, subchannel 5
        expect_wr('h300, 5, 32'h0FFF, 1, "R4 imm eng");
        send(hdr(4, 5, 'h0FFF, 'h300));

        // R1 R7: incrementing burst of 3 on engine
        expect_wr('h200, 2, 32'hA0, 0, "R1 inc w0");
        expect_wr('h201, 2, 32'hA1, 0, "R1 inc w1");
        expect_wr('h202, 2, 32'hA2, 1, "R1 inc w2");
        send(hdr(1, 2, 3, 'h200));
        send(32'hA0); send(32'hA1); send(32'hA2);

        // R2 R6: non-incrementing burst on register 0x10 (byte 0x40)
        for (int i = 0; i < 3; i++) expect_wr('h10, 0, 32'hB0 + 32'(i), 0, "R2 noninc");
        send(hdr(3, 1, 3, 'h10));
        for (int i = 0; i < 3; i++) send(32'hB0 + 32'(i));

        // R3 R8 R9: increment-once on macro 0xE10: start idx 8, then push idx 8
        expect_wr('hE10, 0, 32'hC0, 0, "R3 once first");
        expect_wr('hE11, 0, 32'hC1, 0, "R3 once second");
        expect_wr('hE11, 0, 32'hC2, 1, "R9 once last");
        send(hdr(5, 0, 3, 'hE10));
        send(32'hC0); send(32'hC1); send(32'hC2);

        // R8 R9: odd address pushes, next even starts the following index
        expect_wr('hE21, 0, 32'hD0, 0, "R8 push odd");
        expect_wr('hE22, 0, 32'hD1, 1, "R8 start even");
        send(hdr(1, 0, 2, 'hE21));
        send(32'hD0); send(32'hD1);

        // R9: immediate on macro range raises last
        expect_wr('hFFF, 0, 32'h7, 1, "R9 imm macro last");
        send(hdr(4, 0, 7, 'hFFF));

        // R6 R7 R8: range edges
        expect_wr('h5F, 0, 32'h11, 0, "R6 edge 0x5F");
        expect_wr('h60, 3, 32'h12, 0, "R7 edge 0x60");
        send(hdr(1, 3, 2, 'h5F)); send(32'h11); send(32'h12);
        expect_wr('hDFF, 6, 32'h13, 0, "R7 edge 0xDFF");
        expect_wr('hE00, 6, 32'h14, 1, "R8 edge 0xE00");
        send(hdr(1, 6, 2, 'hDFF)); send(32'h13); send(32'h14);

        // R5: count-zero burst header writes nothing; next word is a header
        send(hdr(1, 0, 0, 'h20));
        expect_wr('h21, 0, 32'h55, 1, "R5 after zero count");
        send(hdr(4, 0, 'h55, 'h21));

        // R10: ignored opcodes mid-stream; a reg-range address shows any leak
        send(hdr(0, 0, 3, 'h01)); send(hdr(2, 0, 3, 'h02));
        send(hdr(6, 0, 3, 'h03)); send(hdr(7, 0, 3, 'h04));
        expect_wr('h06, 0, 32'h66, 1, "R10 after ignored");
        send(hdr(4, 0, 'h66, 'h06));

        // R11: engine backpressure holds the write and the input
        #1 eng_ready = 1'b0;
        expect_wr('h400, 1, 32'h77, 1, "R11 stalled eng write");
        fork
            send(hdr(4, 1, 'h77, 'h400));
            begin
                repeat (3) @(negedge clk);
                chk(!word_ready && eng_we, "R11 stall eng", 52'({word_ready, eng_we}), 52'b01);
                @(posedge clk); #1 eng_ready = 1'b1;
            end
        join
        // R11: macro backpressure
        #1 mac_ready = 1'b0;
        expect_wr('hE31, 0, 32'h3, 1, "R11 stalled mac write");
        fork
            send(hdr(4, 0, 3, 'hE31));
            begin
                repeat (2) @(negedge clk);
                chk(!word_ready && mac_push, "R11 stall mac", 52'({word_ready, mac_push}), 52'b01);
                @(posedge clk); #1 mac_ready = 1'b1;
            end
        join

        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R5 all expected writes seen", 52'(q.size()), 52'd0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule